// File: doc/BRIEF.md
# ADC Result Holding Register

This block keeps the most recent 10-bit analog conversion result and shows it to the register bus as a high byte and a low byte. A conversion sequencer sends a one-cycle valid strobe together with the new code. A code of 0x000 means ground. A code of 0x3FF means full scale less one LSB. An alignment input picks how the code is split across the two bytes. Right alignment suits full 10-bit reads. Left alignment lets software read only the high byte and get an 8-bit result.

The bus reads the two bytes as a pair. Software reads the low byte first. That read locks the register, so a conversion that finishes before the high byte is read cannot mix a new high part with an old low part. Reading the high byte releases the lock. A result that arrives while the register is locked is discarded, and a status pulse reports the loss. A separate pulse fires only for results that are actually stored, so any flag logic downstream agrees with the held data. The alignment input acts on the byte outputs in the same cycle. It needs no new conversion.

Top module: `adc_result_reg`

## Requirements
- R1: With `left_adj`=0, `hi_byte` carries result bits 9:8 in its bits 1:0 with zeros in bits 7:2, and `lo_byte` carries result bits 7:0.
- R2: With `left_adj`=1, `hi_byte` carries result bits 9:2, and `lo_byte` carries result bits 1:0 in its bits 7:6 with zeros in bits 5:0.
- R3: A `rd_lo` pulse without `rd_hi` locks the register from the next cycle. While it is locked, arriving results do not change the held value.
- R4: A `rd_hi` pulse unlocks the register from the next cycle. A result that arrives in the same cycle as the releasing `rd_hi` is still discarded. A read of only `hi_byte` leaves the register unlocked, and the next result is stored.
- R5: A change of `left_adj` changes both byte outputs in the same cycle. The held result is not rewritten.
- R6: After a synchronous reset, both bytes read 0x00, the register is unlocked, and both status pulses are low.
- R7: A result that is discarded causes `upd_dropped` to be high for exactly the cycle after its strobe.
- R8: An accepted result causes `upd_done` to be high for exactly the cycle after its strobe, and the new value appears on the bytes in that same cycle. `upd_done` and `upd_dropped` are never high together.
- R9: A result whose strobe coincides with a `rd_lo` pulse is discarded, so the byte pair being read stays coherent.
- R10: `rd_lo` and `rd_hi` in the same cycle count as a complete read and leave the register unlocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res_valid | input | 1 | One-cycle strobe: a new conversion result is present |
| res_data | input | RES_W | Conversion result code |
| left_adj | input | 1 | 1 selects left alignment, 0 selects right alignment |
| rd_lo | input | 1 | Bus read of the low byte |
| rd_hi | input | 1 | Bus read of the high byte |
| lo_byte | output | 8 | Low byte of the aligned result |
| hi_byte | output | 8 | High byte of the aligned result |
| upd_done | output | 1 | Pulse: a result was stored |
| upd_dropped | output | 1 | Pulse: a result was discarded |

## Verification
The bench targets three boundaries of the lock:
- A result that lands in the same cycle as a low-byte read. A design that let it through would return a torn byte pair.
- A result that lands in the same cycle as the releasing high-byte read. A design that released the lock too early would store this result and give no drop pulse.
- A sequence of high-only reads. A design that set the lock on any read would leave the register stuck.

The bench also toggles the alignment with no conversion in flight. A design that latched the alignment at write time would keep the old byte layout. The extreme codes 0x000 and 0x3FF, and long random mixes, show whether any bit lands in the wrong lane.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
  } byte_pair_t;
endpackage

// File: rtl/adc_res_lock.sv
module adc_res_lock (
  input  logic clk,
  input  logic rst,
  input  logic res_valid,
  input  logic rd_lo,
  input  logic rd_hi,
  output logic accept,
  output logic locked
);
  logic lock_q;

  // accept only when unlocked and no low-byte read is in flight (R9)
  assign accept = res_valid && !lock_q && !rd_lo;
  assign locked = lock_q;

  always_ff @(posedge clk) begin
    if (rst)        lock_q <= 1'b0;
    else if (rd_hi) lock_q <= 1'b0;
    else if (rd_lo) lock_q <= 1'b1;
  end

  p_lo_locks_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && !rd_hi) |=> lock_q);
  p_hi_unlocks_r4: assert property (@(posedge clk) disable iff (rst)
    rd_hi |=> !lock_q);
  p_pair_read_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && rd_hi) |=> !lock_q);
endmodule

// File: rtl/adc_res_store.sv
module adc_res_store #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  output logic [RES_W-1:0] held,
  output logic             upd_done,
  output logic             upd_dropped
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held        <= '0;
      upd_done    <= 1'b0;
      upd_dropped <= 1'b0;
    end else begin
      if (accept) held <= res_data;
      upd_done    <= accept;
      upd_dropped <= res_valid && !accept;
    end
  end

  p_write_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && accept) |=> (upd_done && held == $past(res_data)));
  p_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !accept) |=> (upd_dropped && $stable(held)));
  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(upd_done && upd_dropped));
endmodule

// File: rtl/adc_res_align.sv
module adc_res_align #(
  parameter int RES_W = 10
) (
  input  logic                    left_adj,
  input  logic [RES_W-1:0]        held,
  output adc_res_pkg::byte_pair_t pair
);
  import adc_res_pkg::*;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int PAD_W  = WORD_W - RES_W;

  logic [WORD_W-1:0] word_r, word_l;

  generate
    if (PAD_W > 0) begin : g_pad
      assign word_r = {{PAD_W{1'b0}}, held};
      assign word_l = {held, {PAD_W{1'b0}}};
    end else begin : g_full
      assign word_r = held[WORD_W-1:0];
      assign word_l = held[WORD_W-1:0];
    end
  endgenerate

  assign pair = left_adj ? word_l : word_r;
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_data,
  input  logic             left_adj,
  input  logic             rd_lo,
  input  logic             rd_hi,
  output logic [7:0]       lo_byte,
  output logic [7:0]       hi_byte,
  output logic             upd_done,
  output logic             upd_dropped
);
  import adc_res_pkg::*;

  logic             accept, locked;
  logic [RES_W-1:0] held;
  byte_pair_t       pair;

  adc_res_lock u_lock (
    .clk(clk), .rst(rst), .res_valid(res_valid), .rd_lo(rd_lo),
    .rd_hi(rd_hi), .accept(accept), .locked(locked)
  );

  adc_res_store #(.RES_W(RES_W)) u_store (
    .clk(clk), .rst(rst), .accept(accept), .res_valid(res_valid),
    .res_data(res_data), .held(held), .upd_done(upd_done),
    .upd_dropped(upd_dropped)
  );

  adc_res_align #(.RES_W(RES_W)) u_align (
    .left_adj(left_adj), .held(held), .pair(pair)
  );

  assign lo_byte = pair.lo;
  assign hi_byte = pair.hi;

  p_locked_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (locked && res_valid) |=> (upd_dropped && !upd_done));
  p_right_fmt_r1: assert property (@(posedge clk) disable iff (rst)
    !left_adj |-> (hi_byte[7:2] == 6'd0));
  p_left_fmt_r2: assert property (@(posedge clk) disable iff (rst)
    left_adj |-> (lo_byte[5:0] == 6'd0));
  p_adj_only_r5: assert property (@(posedge clk) disable iff (rst)
    (!res_valid && $past(!res_valid)) |-> !upd_done);
endmodule

// File: tb/adc_result_reg_test.sv
module adc_result_reg_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst = 1;
  logic res_valid = 0, left_adj = 0, rd_lo = 0, rd_hi = 0;
  logic [9:0] res_data = '0;
  logic [7:0] lo_byte, hi_byte;
  logic upd_done, upd_dropped;

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R6";

  int m_held = 0, m_lock = 0, m_done = 0, m_drop = 0;

  adc_result_reg uut (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .left_adj(left_adj), .rd_lo(rd_lo), .rd_hi(rd_hi), .lo_byte(lo_byte),
    .hi_byte(hi_byte), .upd_done(upd_done), .upd_dropped(upd_dropped)
  );

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference
  always @(posedge clk) begin
    if (rst) begin
      m_held = 0; m_lock = 0; m_done = 0; m_drop = 0;
    end else begin
      bit acc;
      acc = res_valid && (m_lock == 0) && !rd_lo;
      m_done = acc;
      m_drop = res_valid && !acc;
      if (acc) m_held = res_data;
      if (rd_hi) m_lock = 0;
      else if (rd_lo) m_lock = 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int eh, el;
    if (left_adj) begin
      eh = (m_held >> 2) & 8'hff;
      el = (m_held & 3) << 6;
    end else begin
      eh = (m_held >> 8) & 3;
      el = m_held & 8'hff;
    end
    chk({tag, " hi_byte"}, hi_byte, eh);
    chk({tag, " lo_byte"}, lo_byte, el);
    chk({tag, " upd_done"}, upd_done, m_done);
    chk({tag, " upd_dropped"}, upd_dropped, m_drop);
  endtask

  // drive at negedge, let one edge pass, compare at next negedge
  task automatic cyc(input bit v, input int d, input bit adj,
                     input bit lo, input bit hi);
    res_valid = v; res_data = d[9:0]; left_adj = adj; rd_lo = lo; rd_hi = hi;
    @(negedge clk);
    compare();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R6";
    compare();                          // reset state
    cyc(0, 0, 1, 0, 0);                 // R6 zero in left form as well

    tag = "R1";                         // right alignment, extremes
    cyc(1, 10'h3FF, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(1, 10'h000, 0, 0, 0);
    cyc(1, 10'h2A5, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);

    tag = "R2";
    cyc(1, 10'h3FF, 1, 0, 0);
    cyc(1, 10'h156, 1, 0, 0);
    cyc(0, 0, 1, 0, 0);

    tag = "R5";                         // toggle alignment, no conversion
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);

    tag = "R3";                         // low read locks, results dropped (R7)
    cyc(0, 0, 0, 1, 0);
    cyc(1, 10'h0F0, 0, 0, 0);
    cyc(1, 10'h30F, 1, 0, 0);
    tag = "R4";                         // result with releasing high read dropped
    cyc(1, 10'h111, 0, 0, 1);
    cyc(1, 10'h222, 0, 0, 0);           // stored now (R8)
    tag = "R9";
    cyc(1, 10'h333, 0, 1, 0);
    cyc(0, 0, 0, 0, 1);
    tag = "R4";                         // high-only reads never lock
    cyc(0, 0, 1, 0, 1);
    cyc(0, 0, 1, 0, 1);
    cyc(1, 10'h1C3, 1, 0, 0);
    tag = "R10";
    cyc(0, 0, 0, 1, 1);
    cyc(1, 10'h0AB, 0, 0, 0);

    tag = "R7/R8 mix";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      cyc(r[0] | r[1], $urandom % 1024, r[2], r[3] & r[4], r[5] & r[6]);
    end
    finish_run();
  end
endmodule